// File: doc/BRIEF.md
# Dual-Channel DDR Input Elastic Buffer

This block is the front end of a converter that takes sample words from an FPGA over a source-synchronous double-data-rate bus. The word on the bus at the rising edge of the data clock and the word at the following falling edge form one pair. The pair is assembled in the data-clock domain and written into an eight-entry asynchronous FIFO. The FIFO is drained in the converter sample-clock domain. Both clocks run at the same frequency, but the phase between them is unknown and fixed. The FIFO absorbs that phase offset.

The input can be read three ways. In dual-channel mode, each edge carries one channel. In single-channel mode, the falling-edge word is dropped. In split mode, the bus is treated as two 7-bit DDR lanes.

The read side is a small state machine with three states:
- `RD_FILL`: waits until the read side's estimate of FIFO occupancy reaches a start level.
- `RD_RUN`: streams one pair per cycle.
- `RD_SLIP`: a single cycle that moves the read pointer forward after an overflow.

The transitions are:
- start (`RD_FILL` to `RD_RUN`)
- underflow (`RD_RUN` to `RD_FILL`)
- overflow (`RD_RUN` to `RD_SLIP`)
- re-centre (`RD_SLIP` to `RD_FILL`)

Overflow and underflow are reported as sticky flags in the sample-clock domain.

Top module: `ddr_eb_top`

## Requirements
- R1: With `mode_sel` = 2'b00, the bus word sampled on a rising data-clock edge appears on `dout_a`. The word sampled on the next falling edge appears on `dout_b` in the same output cycle. Pairs leave in the order they arrived.
- R2: With `mode_sel` = 2'b01, `dout_b` is zero and `dout_a` carries the rising-edge words in order. With 2'b10 (split), the rising word is r and the falling word is f, and the outputs are `dout_a` = {f[6:0], r[6:0]} and `dout_b` = {f[13:7], r[13:7]}. The value 2'b11 behaves as 2'b00.
- R3: While `r_rst_n` is low, `dout_valid`, `ovf_flag`, `udf_flag`, `dout_a` and `dout_b` are all zero.
- R4: After reset, no pair is output until the read-side occupancy estimate (synchronized write count minus read count) reaches 3. With equal clock frequencies and any phase, `dout_valid` then stays high and neither flag is set.
- R5: If the occupancy estimate is 0 in `RD_RUN`, the block does the following:
  - sets `udf_flag`;
  - drops `dout_valid`;
  - holds `dout_a` and `dout_b` at the last pair;
  - resumes once the estimate is back at 3, with no pair lost or repeated.
- R6: If the occupancy estimate reaches 5 in `RD_RUN`, the block does the following:
  - sets `ovf_flag`;
  - keeps `dout_valid` low for at least two cycles;
  - moves the read pointer to 3 entries behind the synchronized write pointer.
- R7: The two flags stay set until `clr_flags` is high at a sample-clock rising edge, which clears them. When the clock frequencies are equal, they then stay clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Data clock from the source; both edges carry data |
| w_rst_n | input | 1 | Active-low asynchronous reset, data-clock domain |
| rclk | input | 1 | Converter sample clock, read domain |
| r_rst_n | input | 1 | Active-low asynchronous reset, sample-clock domain |
| mode_sel | input | 2 | Input mode: 00 dual, 01 single, 10 split, 11 dual |
| din | input | 14 | DDR sample bus |
| clr_flags | input | 1 | Synchronous clear of both sticky flags (sample clock) |
| dout_a | output | 14 | Channel A word |
| dout_b | output | 14 | Channel B word |
| dout_valid | output | 1 | High in each cycle a new pair is presented |
| ovf_flag | output | 1 | Sticky overflow indication |
| udf_flag | output | 1 | Sticky underflow indication |

## Verification
The assertions check the following on every cycle:
- Each flag rises only when the occupancy estimate has crossed its threshold.
- Output data never moves while `dout_valid` is low.
- A new stream never starts below the start level.
- The flags stay set until cleared.

Only the bench scenarios can show whether the pairs come out in the right order and with the right per-mode layout for a random clock phase. The same applies to whether a slow or fast data clock actually drives the buffer into underflow or overflow, and whether clearing leaves the flags quiet once the clocks match.

// File: rtl/ddr_eb_pkg.sv
package ddr_eb_pkg;

    // Bus interpretation selected by mode_sel
    typedef enum logic [1:0] {
        MODE_DUAL     = 2'b00,
        MODE_SINGLE   = 2'b01,
        MODE_SPLIT    = 2'b10,
        MODE_DUAL_ALT = 2'b11
    } in_mode_e;

    // Read-side control states
    typedef enum logic [1:0] {
        RD_FILL = 2'b00,
        RD_RUN  = 2'b01,
        RD_SLIP = 2'b10
    } rd_state_e;

endpackage

// File: rtl/ddr_eb_sync.sv
module ddr_eb_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/ddr_eb_wside.sv
module ddr_eb_wside
    import ddr_eb_pkg::*;
#(
    parameter int DW = 14,
    parameter int AW = 3
) (
    input  logic            wclk,
    input  logic            w_rst_n,
    input  in_mode_e        mode,
    input  logic [DW-1:0]   din,
    input  logic [AW-1:0]   rd_addr,
    output logic [2*DW-1:0] rd_pair,
    output logic [AW:0]     wr_gray
);
    localparam int HALF  = DW / 2;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]   rise_q;
    logic [DW-1:0]   fall_q;
    logic            primed;
    logic [DW-1:0]   word_a;
    logic [DW-1:0]   word_b;
    logic [AW:0]     wr_bin;
    logic [AW:0]     wr_bin_nx;
    logic [2*DW-1:0] mem [DEPTH];

    // Rising-edge capture; primed marks that a full pair exists
    always_ff @(posedge wclk or negedge w_rst_n) begin
        if (!w_rst_n) begin
            rise_q <= '0;
            primed <= 1'b0;
        end else begin
            rise_q <= din;
            primed <= 1'b1;
        end
    end

    // Falling-edge capture
    always_ff @(negedge wclk or negedge w_rst_n) begin
        if (!w_rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= din;
        end
    end

    // Channel mapping per input mode
    always_comb begin
        word_a = rise_q;
        word_b = fall_q;
        unique case (mode)
            MODE_SINGLE: word_b = '0;
            MODE_SPLIT: begin
                word_a = {fall_q[HALF-1:0],  rise_q[HALF-1:0]};
                word_b = {fall_q[DW-1:HALF], rise_q[DW-1:HALF]};
            end
            default: begin
                word_a = rise_q;
                word_b = fall_q;
            end
        endcase
    end

    assign wr_bin_nx = wr_bin + 1'b1;

    always_ff @(posedge wclk or negedge w_rst_n) begin
        if (!w_rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (primed) begin
            wr_bin  <= wr_bin_nx;
            wr_gray <= wr_bin_nx ^ (wr_bin_nx >> 1);
        end
    end

    always_ff @(posedge wclk) begin
        if (primed) begin
            mem[wr_bin[AW-1:0]] <= {word_a, word_b};
        end
    end

    assign rd_pair = mem[rd_addr];
endmodule

// File: rtl/ddr_eb_rside.sv
module ddr_eb_rside
    import ddr_eb_pkg::*;
#(
    parameter int DW        = 14,
    parameter int AW        = 3,
    parameter int START_LVL = 3,
    parameter int HIGH_LVL  = 5
) (
    input  logic            rclk,
    input  logic            r_rst_n,
    input  logic            clr_flags,
    input  logic [AW:0]     wr_gray_s,
    input  logic [2*DW-1:0] rd_pair,
    output logic [AW-1:0]   rd_addr,
    output logic [AW:0]     level,
    output logic [DW-1:0]   dout_a,
    output logic [DW-1:0]   dout_b,
    output logic            dout_valid,
    output logic            ovf_flag,
    output logic            udf_flag
);
    localparam logic [AW:0] START = (AW+1)'(START_LVL);
    localparam logic [AW:0] HIGH  = (AW+1)'(HIGH_LVL);

    rd_state_e   state, nxt;
    logic [AW:0] wr_bin;
    logic [AW:0] rptr;
    logic        rd, jump, ovf_hit, udf_hit;

    // Gray to binary of the synchronized write pointer
    always_comb begin
        for (int i = 0; i <= AW; i++) begin
            wr_bin[i] = ^(wr_gray_s >> i);
        end
    end

    assign level   = wr_bin - rptr;
    assign rd_addr = rptr[AW-1:0];

    // Next-state and per-cycle controls
    always_comb begin
        nxt     = state;
        rd      = 1'b0;
        jump    = 1'b0;
        ovf_hit = 1'b0;
        udf_hit = 1'b0;
        unique case (state)
            RD_FILL: begin
                if (level >= START) begin
                    rd  = 1'b1;
                    nxt = RD_RUN;
                end
            end
            RD_RUN: begin
                if (level == '0) begin
                    udf_hit = 1'b1;
                    nxt     = RD_FILL;
                end else if (level >= HIGH) begin
                    ovf_hit = 1'b1;
                    nxt     = RD_SLIP;
                end else begin
                    rd = 1'b1;
                end
            end
            RD_SLIP: begin
                jump = 1'b1;
                nxt  = RD_FILL;
            end
            default: nxt = RD_FILL;
        endcase
    end

    // State register
    always_ff @(posedge rclk or negedge r_rst_n) begin
        if (!r_rst_n) begin
            state <= RD_FILL;
        end else begin
            state <= nxt;
        end
    end

    // Outputs, read pointer and sticky flags
    always_ff @(posedge rclk or negedge r_rst_n) begin
        if (!r_rst_n) begin
            rptr       <= '0;
            dout_a     <= '0;
            dout_b     <= '0;
            dout_valid <= 1'b0;
            ovf_flag   <= 1'b0;
            udf_flag   <= 1'b0;
        end else begin
            rptr       <= jump ? (wr_bin - START) : (rptr + {{AW{1'b0}}, rd});
            dout_valid <= rd;
            if (rd) begin
                dout_a <= rd_pair[2*DW-1:DW];
                dout_b <= rd_pair[DW-1:0];
            end
            ovf_flag <= ovf_hit | (ovf_flag & ~clr_flags);
            udf_flag <= udf_hit | (udf_flag & ~clr_flags);
        end
    end
endmodule

// File: rtl/ddr_eb_top.sv
module ddr_eb_top
    import ddr_eb_pkg::*;
#(
    parameter int DW    = 14,
    parameter int DEPTH = 8
) (
    input  logic          wclk,
    input  logic          w_rst_n,
    input  logic          rclk,
    input  logic          r_rst_n,
    input  logic [1:0]    mode_sel,
    input  logic [DW-1:0] din,
    input  logic          clr_flags,
    output logic [DW-1:0] dout_a,
    output logic [DW-1:0] dout_b,
    output logic          dout_valid,
    output logic          ovf_flag,
    output logic          udf_flag
);
    localparam int AW        = $clog2(DEPTH);
    localparam int START_LVL = DEPTH / 2 - 1;
    localparam int HIGH_LVL  = DEPTH - 3;

    logic [AW:0]     wr_gray;
    logic [AW:0]     wr_gray_s;
    logic [AW-1:0]   rd_addr;
    logic [2*DW-1:0] rd_pair;
    logic [AW:0]     rd_level;

    ddr_eb_wside #(.DW(DW), .AW(AW)) wside_i (
        .wclk    (wclk),
        .w_rst_n (w_rst_n),
        .mode    (in_mode_e'(mode_sel)),
        .din     (din),
        .rd_addr (rd_addr),
        .rd_pair (rd_pair),
        .wr_gray (wr_gray)
    );

    ddr_eb_sync #(.W(AW + 1)) wsync_i (
        .clk   (rclk),
        .rst_n (r_rst_n),
        .d     (wr_gray),
        .q     (wr_gray_s)
    );

    ddr_eb_rside #(
        .DW(DW), .AW(AW), .START_LVL(START_LVL), .HIGH_LVL(HIGH_LVL)
    ) rside_i (
        .rclk       (rclk),
        .r_rst_n    (r_rst_n),
        .clr_flags  (clr_flags),
        .wr_gray_s  (wr_gray_s),
        .rd_pair    (rd_pair),
        .rd_addr    (rd_addr),
        .level      (rd_level),
        .dout_a     (dout_a),
        .dout_b     (dout_b),
        .dout_valid (dout_valid),
        .ovf_flag   (ovf_flag),
        .udf_flag   (udf_flag)
    );
endmodule

// File: rtl/ddr_eb_chk.sv
module ddr_eb_chk #(
    parameter int DW        = 14,
    parameter int AW        = 3,
    parameter int START_LVL = 3,
    parameter int HIGH_LVL  = 5
) (
    input logic          rclk,
    input logic          r_rst_n,
    input logic          clr_flags,
    input logic          dout_valid,
    input logic [DW-1:0] dout_a,
    input logic [DW-1:0] dout_b,
    input logic          ovf_flag,
    input logic          udf_flag,
    input logic [AW:0]   level
);
    localparam logic [AW:0] START = (AW+1)'(START_LVL);
    localparam logic [AW:0] HIGH  = (AW+1)'(HIGH_LVL);

    // R3: quiet outputs while held in reset
    a_r3_reset_idle: assert property (@(posedge rclk)
        !r_rst_n |=> (!dout_valid && !ovf_flag && !udf_flag));

    // R4: a stream only begins at or above the start level
    a_r4_start_level: assert property (@(posedge rclk) disable iff (!r_rst_n)
        $rose(dout_valid) |-> ($past(level) >= START));

    // R5: underflow flag only when the estimate was empty
    a_r5_udf_cause: assert property (@(posedge rclk) disable iff (!r_rst_n)
        $rose(udf_flag) |-> ($past(level) == '0));

    // R5: output pair frozen while no valid data
    a_r5_hold_gap: assert property (@(posedge rclk) disable iff (!r_rst_n)
        !dout_valid |-> ($stable(dout_a) && $stable(dout_b)));

    // R6: overflow flag only at or above the high level
    a_r6_ovf_cause: assert property (@(posedge rclk) disable iff (!r_rst_n)
        $rose(ovf_flag) |-> ($past(level) >= HIGH));

    // R6: at least two invalid cycles around the slip
    a_r6_ovf_gap: assert property (@(posedge rclk) disable iff (!r_rst_n)
        $rose(ovf_flag) |-> (!dout_valid ##1 !dout_valid));

    // R7: flags are sticky until cleared
    a_r7_ovf_sticky: assert property (@(posedge rclk) disable iff (!r_rst_n)
        (ovf_flag && !clr_flags) |=> ovf_flag);

    a_r7_udf_sticky: assert property (@(posedge rclk) disable iff (!r_rst_n)
        (udf_flag && !clr_flags) |=> udf_flag);
endmodule

bind ddr_eb_top ddr_eb_chk #(
    .DW(DW), .AW(AW), .START_LVL(START_LVL), .HIGH_LVL(HIGH_LVL)
) chk_i (
    .rclk       (rclk),
    .r_rst_n    (r_rst_n),
    .clr_flags  (clr_flags),
    .dout_valid (dout_valid),
    .dout_a     (dout_a),
    .dout_b     (dout_b),
    .ovf_flag   (ovf_flag),
    .udf_flag   (udf_flag),
    .level      (rd_level)
);

// File: tb/ddr_eb_top_tb_top.sv
`timescale 1ns/1ps
module ddr_eb_top_tb_top;
    localparam int DW        = 14;
    localparam int START_LVL = 3;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          w_rst_n = 1'b0, r_rst_n = 1'b0, clr_flags = 1'b0;
    logic [1:0]    mode_sel = 2'b00;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout_a, dout_b;
    logic          dout_valid, ovf_flag, udf_flag;

    real wper = 5.0, rper = 5.0, rshift = 0.0;
    int  k = 0, ridx = 0, n_cmp = 0, n_bad = 0, gaps = 0, k_first = -1;
    bit  drv = 0, chk_on = 0, ord_on = 0, have_last = 0, done = 0;
    string ord_req = "R1";
    logic [2*DW-1:0] last_pair = '0;
    int unsigned seed_init;

    ddr_eb_top dut_i (
        .wclk(wclk), .w_rst_n(w_rst_n), .rclk(rclk), .r_rst_n(r_rst_n),
        .mode_sel(mode_sel), .din(din), .clr_flags(clr_flags),
        .dout_a(dout_a), .dout_b(dout_b), .dout_valid(dout_valid),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    initial forever #(wper/2.0) wclk = ~wclk;

    initial begin
        forever begin
            #(rper/2.0) rclk = 1'b1;
            #(rper/2.0) rclk = 1'b0;
            if (rshift > 0.0) begin
                #(rshift);
                rshift = 0.0;
            end
        end
    end

    function automatic logic [DW-1:0] bus_word(int idx, int salt);
        logic [31:0] h;
        h = 32'(idx) * 32'h9E3779B1 + 32'(salt) * 32'h7F4A7C15;
        h = h ^ (h >> 13);
        return h[DW+2:3];
    endfunction

    function automatic logic [2*DW-1:0] exp_pair(int idx, logic [1:0] m);
        logic [DW-1:0] r, f;
        r = bus_word(idx, 1);
        f = bus_word(idx, 2);
        case (m)
            2'b01:   return {r, {DW{1'b0}}};
            2'b10:   return {f[6:0], r[6:0], f[13:7], r[13:7]};
            default: return {r, f};
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // DDR source: rising word A(k), falling word B(k)
    initial begin
        bit act;
        forever begin
            @(posedge wclk);
            act = drv;
            #(wper * 0.25);
            if (act) din = bus_word(k, 2);
            @(negedge wclk);
            #(wper * 0.25);
            if (act) begin
                k++;
                din = bus_word(k, 1);
            end
        end
    end

    // Output monitor, sampled away from the rising edge
    initial begin
        forever begin
            @(negedge rclk);
            if (chk_on && r_rst_n) begin
                if (dout_valid) begin
                    if (k_first < 0) k_first = k;
                    if (ord_on) check(ord_req, 32'({dout_a, dout_b}), 32'(exp_pair(ridx, mode_sel)));
                    ridx++;
                    have_last = 1;
                    last_pair = {dout_a, dout_b};
                end else if (have_last) begin
                    gaps++;
                    check("R5 hold", 32'({dout_a, dout_b}), 32'(last_pair));
                end
            end
        end
    end

    task automatic start(logic [1:0] m);
        chk_on = 0; drv = 0; ord_on = 0;
        w_rst_n = 0; r_rst_n = 0; clr_flags = 0;
        mode_sel = m;
        rshift = real'($urandom % 500) / 100.0;
        repeat (6) @(posedge wclk);
        @(negedge rclk); #0.2;
        check("R3 valid", 32'(dout_valid), 0);
        check("R3 flags", 32'({ovf_flag, udf_flag}), 0);
        check("R3 data", 32'({dout_a, dout_b}), 0);
        ridx = 0; have_last = 0; gaps = 0; k_first = -1;
        r_rst_n = 1; chk_on = 1;
        @(negedge wclk); #0.1;
        k = 0;
        din = bus_word(0, 1);
        w_rst_n = 1;
        drv = 1;
    endtask

    task automatic run_steady(logic [1:0] m, string req);
        start(m);
        ord_req = req;
        ord_on = 1;
        repeat (250) @(posedge rclk);
        #0.5;
        check("R4 no gaps", 32'(gaps), 0);
        check("R4 no flags", 32'({ovf_flag, udf_flag}), 0);
        check("R4 streamed", 32'(ridx > 200), 1);
        check("R4 start level", 32'(k_first >= START_LVL), 1);
    endtask

    initial begin
        seed_init = $urandom(32'd4242);
        for (int i = 0; i < 4; i++) run_steady(2'b00, "R1 order");
        run_steady(2'b01, "R2 single");
        run_steady(2'b10, "R2 split");
        run_steady(2'b11, "R2 alt dual");

        // R5: slow data clock drains the buffer
        wper = 5.25;
        start(2'b00);
        ord_req = "R5 order";
        ord_on = 1;
        repeat (600) @(posedge rclk);
        #0.5;
        check("R5 udf set", 32'(udf_flag), 1);
        check("R5 no ovf", 32'(ovf_flag), 0);
        check("R5 gaps seen", 32'(gaps > 0), 1);
        wper = 5.0;

        // R6: fast data clock fills the buffer
        wper = 4.75;
        start(2'b00);
        repeat (600) @(posedge rclk);
        #0.5;
        check("R6 ovf set", 32'(ovf_flag), 1);
        check("R6 no udf", 32'(udf_flag), 0);

        // R7: sticky, then cleared once clocks match
        wper = 5.0;
        repeat (60) @(posedge rclk);
        #0.5;
        check("R7 sticky", 32'(ovf_flag), 1);
        @(posedge rclk); #1.0; clr_flags = 1;
        @(posedge rclk); #1.0; clr_flags = 0;
        @(negedge rclk);
        check("R7 cleared", 32'({ovf_flag, udf_flag}), 0);
        repeat (100) @(posedge rclk);
        #0.5;
        check("R7 stays clear", 32'({ovf_flag, udf_flag}), 0);
        check("R7 streaming", 32'(dout_valid), 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule